// File: doc/BRIEF.md
# Disk Adapter Status Handshake Registers

This block holds the small register set a host uses to talk to a simple hard-disk adapter through two I/O addresses. One address is a control register on write and a status register on read. The other is an attention register on write and an interrupt-status register on read. Writes to control and attention move the status register. Reading interrupt status acknowledges the pending interrupt flag.

A device-side model raises the interrupt flag through a single strobe input. The host sees the flag on an interrupt-pending output. All four register values are also brought out as ports, so that neighbouring logic can act on them. Data transfer, command execution and DMA are handled elsewhere.

Top module: `dsk_hs_regs`

## Requirements
- R1: After reset, the control, attention, status and interrupt-status registers are all 0x00 and the interrupt-pending output is low.
- R2: A read at the status address 0x322 returns the status register on bus_rdata in the same cycle, and it leaves every register unchanged.
- R3: A write at 0x322 stores the full byte into control. When bit 7 of the byte is 1, status bit 1 is set and the other status bits are kept. When bit 7 is 0, status is unchanged.
- R4: A write at 0x324 stores only bits 7:4 of the byte into attention, and attention bits 3:0 become 0.
- R5: When bits 7:4 of an attention write are not all zero, status is loaded with 0x14, whatever its earlier value. When they are all zero, status is unchanged.
- R6: A read at 0x324 returns the interrupt-status register in the same cycle. From the next cycle on, bit 1 of that register is 0.
- R7: A one-cycle pulse on dev_irq_set sets interrupt-status bit 1 from the next cycle on. irq_pending always equals that bit.
- R8: When dev_irq_set and a read of 0x324 fall in the same cycle, the read returns the value held before that cycle, and bit 1 is 1 afterwards (the set wins).
- R9: A read of any address other than 0x322 and 0x324 returns 0xFF. A write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Host I/O address |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte, valid in the strobe cycle |
| dev_irq_set | input | 1 | Device request to raise the interrupt flag |
| ctrl_q | output | 8 | Control register |
| attn_q | output | 8 | Attention register (low nibble always 0) |
| stat_q | output | 8 | Status register |
| istat_q | output | 8 | Interrupt-status register |
| irq_pending | output | 1 | Interrupt flag, equal to interrupt-status bit 1 |

## Verification
The hardest case to reach is a device set landing in the same cycle as the host read that acknowledges it. The bench drives the read strobe and dev_irq_set on the same falling edge. It samples the returned byte before the rising edge and the flag after it. Status has only four reachable values. To cover the transitions between them, the bench sweeps all 256 bytes through control and through attention, interleaving the two writes. This lets every attention load start from 0x02, 0x14 and 0x16.

// File: rtl/dsk_hs_pkg.sv
package dsk_hs_pkg;
  localparam int DW          = 8;
  localparam int ADDR_W      = 16;
  localparam int GO_BIT      = 7;
  localparam int BUSY_BIT    = 1;
  localparam int IRQ_BIT     = 1;
  localparam logic [DW-1:0] ATTN_MASK  = 8'hF0;
  localparam logic [DW-1:0] ATTN_LOAD  = 8'h14;
  localparam logic [DW-1:0] FLOAT_BYTE = 8'hFF;

  // status after a control write
  function automatic logic [DW-1:0] ctrl_fold(logic [DW-1:0] st, logic [DW-1:0] wd);
    logic [DW-1:0] r;
    r = st;
    if (wd[GO_BIT]) r[BUSY_BIT] = 1'b1;
    return r;
  endfunction

  // attention bits kept from a write
  function automatic logic [DW-1:0] attn_keep(logic [DW-1:0] wd);
    return wd & ATTN_MASK;
  endfunction

  // status after an attention write
  function automatic logic [DW-1:0] attn_fold(logic [DW-1:0] st, logic [DW-1:0] nib);
    return (nib != '0) ? ATTN_LOAD : st;
  endfunction
endpackage

// File: rtl/dsk_hs_decode.sv
module dsk_hs_decode
  import dsk_hs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 16'h0322,
  parameter logic [ADDR_W-1:0] ISTAT_ADDR = 16'h0324
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              sel_a,
  output logic              sel_b,
  output logic              wr_ctrl,
  output logic              wr_attn,
  output logic              rd_istat
);
  always_comb begin
    sel_a    = (addr == STAT_ADDR);
    sel_b    = (addr == ISTAT_ADDR);
    wr_ctrl  = wr & sel_a;
    wr_attn  = wr & sel_b;
    rd_istat = rd & sel_b;
  end
endmodule

// File: rtl/dsk_hs_status.sv
module dsk_hs_status
  import dsk_hs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_attn,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] attn_q,
  output logic [DW-1:0] stat_q
);
  logic [DW-1:0] nib;
  assign nib = attn_keep(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      attn_q <= '0;
      stat_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= wdata;
      stat_q <= ctrl_fold(stat_q, wdata);
    end else if (wr_attn) begin
      attn_q <= nib;
      stat_q <= attn_fold(stat_q, nib);
    end
  end

  // R3
  go_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[GO_BIT]) |=> stat_q[BUSY_BIT]);
  // R4
  attn_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_attn |=> (attn_q[3:0] == 4'h0));
  // R5
  attn_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_attn && (wdata[7:4] != 4'h0)) |=> (stat_q == ATTN_LOAD));
  // R2
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ctrl || wr_attn) |=> $stable(stat_q));
endmodule

// File: rtl/dsk_hs_irq.sv
module dsk_hs_irq
  import dsk_hs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_evt,
  input  logic          clr_evt,
  output logic [DW-1:0] istat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      istat_q <= '0;
    else if (set_evt)
      istat_q[IRQ_BIT] <= 1'b1;
    else if (clr_evt)
      istat_q[IRQ_BIT] <= 1'b0;
  end

  // R7
  set_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> istat_q[IRQ_BIT]);
  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !istat_q[IRQ_BIT]);
  // R7
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(istat_q[IRQ_BIT]) |-> $past(set_evt));
endmodule

// File: rtl/dsk_hs_regs.sv
module dsk_hs_regs
  import dsk_hs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 16'h0322,
  parameter logic [ADDR_W-1:0] ISTAT_ADDR = 16'h0324
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              dev_irq_set,
  output logic [DW-1:0]     ctrl_q,
  output logic [DW-1:0]     attn_q,
  output logic [DW-1:0]     stat_q,
  output logic [DW-1:0]     istat_q,
  output logic              irq_pending
);
  logic sel_a, sel_b, wr_ctrl, wr_attn, rd_istat;

  dsk_hs_decode #(.STAT_ADDR(STAT_ADDR), .ISTAT_ADDR(ISTAT_ADDR)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .sel_a(sel_a), .sel_b(sel_b),
    .wr_ctrl(wr_ctrl), .wr_attn(wr_attn), .rd_istat(rd_istat)
  );

  dsk_hs_status u_stat (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_attn(wr_attn),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .attn_q(attn_q), .stat_q(stat_q)
  );

  dsk_hs_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_evt(dev_irq_set), .clr_evt(rd_istat),
    .istat_q(istat_q)
  );

  assign irq_pending = istat_q[IRQ_BIT];

  always_comb begin
    if (sel_a)      bus_rdata = stat_q;
    else if (sel_b) bus_rdata = istat_q;
    else            bus_rdata = FLOAT_BYTE;
  end

  // R9
  float_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !sel_a && !sel_b) |-> (bus_rdata == FLOAT_BYTE));
  // R9
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !sel_a && !sel_b) |=> ($stable(ctrl_q) && $stable(attn_q)));
endmodule

// File: tb/dsk_hs_regs_bench.sv
`timescale 1ns/1ps
module dsk_hs_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, dev_irq_set = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata, ctrl_q, attn_q, stat_q, istat_q;
  logic        irq_pending;
  int total = 0, bad = 0;
  logic [7:0] m_ctrl = 0, m_attn = 0, m_stat = 0, m_ist = 0;
  logic [7:0] got;

  always #10 clk = ~clk;

  dsk_hs_regs u_dsk_hs_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_irq_set(dev_irq_set),
    .ctrl_q(ctrl_q), .attn_q(attn_q), .stat_q(stat_q), .istat_q(istat_q),
    .irq_pending(irq_pending)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic all_regs(string tag);
    chk(tag, ctrl_q, m_ctrl);
    chk(tag, attn_q, m_attn);
    chk(tag, stat_q, m_stat);
    chk(tag, istat_q, m_ist);
    chk(tag, {7'd0, irq_pending}, {7'd0, m_ist[1]});
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, logic set, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; dev_irq_set = set;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; dev_irq_set = 1'b0;
  endtask

  task automatic pulse_set();
    @(negedge clk);
    dev_irq_set = 1'b1;
    @(negedge clk);
    dev_irq_set = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    all_regs("R1");
    rd(16'h0322, 1'b0, got); chk("R1 status read", got, 8'h00);
    rd(16'h0324, 1'b0, got); chk("R1 istat read", got, 8'h00);

    // R3 sweep all control bytes
    for (int v = 0; v < 256; v++) begin
      wr(16'h0322, v[7:0]);
      m_ctrl = v[7:0];
      if (v[7]) m_stat[1] = 1'b1;
      chk("R3 ctrl", ctrl_q, m_ctrl);
      chk("R3 status", stat_q, m_stat);
    end

    // R2 status read without side effect
    rd(16'h0322, 1'b0, got); chk("R2 read", got, m_stat);
    rd(16'h0322, 1'b0, got); chk("R2 reread", got, m_stat);
    all_regs("R2");

    // R4 R5 sweep attention bytes, interleaved with control writes
    for (int v = 0; v < 256; v++) begin
      wr(16'h0322, v[7:0] ^ 8'h80);
      m_ctrl = v[7:0] ^ 8'h80;
      if (m_ctrl[7]) m_stat[1] = 1'b1;
      wr(16'h0324, v[7:0]);
      m_attn = {v[7:4], 4'h0};
      if (v[7:4] != 0) m_stat = 8'h14;
      chk("R4 attn", attn_q, m_attn);
      chk("R5 status", stat_q, m_stat);
      chk("R3 ctrl kept", ctrl_q, m_ctrl);
    end

    // R7 device set, irq_pending follows bit 1
    pulse_set();
    m_ist[1] = 1'b1;
    all_regs("R7");
    // R6 read returns value then clears
    rd(16'h0324, 1'b0, got); chk("R6 read value", got, 8'h02);
    m_ist[1] = 1'b0;
    all_regs("R6 cleared");
    rd(16'h0324, 1'b0, got); chk("R6 second read", got, 8'h00);

    // R8 set and read-clear in the same cycle
    rd(16'h0324, 1'b1, got); chk("R8 read old value", got, 8'h00);
    m_ist[1] = 1'b1;
    all_regs("R8 set wins");
    rd(16'h0324, 1'b1, got); chk("R8 read while set", got, 8'h02);
    all_regs("R8 still set");
    rd(16'h0324, 1'b0, got); chk("R6 ack", got, 8'h02);
    m_ist[1] = 1'b0;
    all_regs("R6 after ack");

    // R9 other addresses
    for (int a = 16'h0300; a < 16'h0340; a++) begin
      if (a != 16'h0322 && a != 16'h0324) begin
        rd(a[15:0], 1'b0, got); chk("R9 float read", got, 8'hFF);
        wr(a[15:0], 8'hF7);
        all_regs("R9 stray write");
      end
    end
    wr(16'h1322, 8'hFF); all_regs("R9 alias write");
    rd(16'h1324, 1'b0, got); chk("R9 alias read", got, 8'hFF);

    // R1 reset again from a busy state
    pulse_set(); wr(16'h0322, 8'h80);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_ctrl = 0; m_attn = 0; m_stat = 0; m_ist = 0;
    all_regs("R1 rereset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule